// File: doc/BRIEF.md
# Thermal Zone Thermometer and Warning Logic

This block turns a digitized temperature-sense voltage into an eight-bit thermometer-coded zone word. It also derives two active-low thermal warnings from that word. The sense voltage arrives as an unsigned millivolt sample with a one-cycle valid strobe. The zone word is recomputed only on strobe cycles. Each bit marks one temperature step: bit 0 is the coolest step and bit 7 the hottest.

The two warnings are a hot flag and an alert flag. Each one asserts when one zone bit sets and releases only when the next lower bit clears, which gives one zone of hysteresis. A status bit follows the alert and does not latch. A register-read port returns the zone word one cycle after a request. When the sense input is flagged as tied to the supply, the thermal function is off:
- the zone word reads zero;
- both warnings stay released;
- every read request is answered with a reject pulse.

Top module: `thermal_zone_alert`

## Requirements
- R1: On a cycle with `smp_vld` high and `sense_off` low, bit i of `zone_q` (i = 0..7) becomes 1 in the next cycle exactly when `smp_mv` >= 1460 + 55*i millivolts. The thresholds run 1460, 1515, 1570, 1625, 1680, 1735, 1790 and 1845.
- R2: On cycles with `smp_vld` low, `zone_q` holds its value. `zone_q` is always a thermometer pattern, meaning all set bits sit below all clear bits.
- R3: When `zone_q[7]` is 1 and `sense_off` is low, `hot_n` is 0 in the next cycle.
- R4: Once asserted, `hot_n` stays 0 until a cycle in which `zone_q[6]` is 0. It is 1 in the cycle after that.
- R5: When `zone_q[6]` is 1 and `sense_off` is low, `alert_n` is 0 in the next cycle.
- R6: Once asserted, `alert_n` stays 0 until a cycle in which `zone_q[5]` is 0. It is 1 in the cycle after that.
- R7: `stat_alert` is 1 exactly while `alert_n` is 0. It does not latch, and read requests do not change it.
- R8: In the cycle after `sense_off` is high, `zone_q` is 0 and `hot_n` and `alert_n` are 1. Samples given while `sense_off` is high have no effect.
- R9: A cycle with `rd_req` high and `sense_off` low yields `rd_ack` = 1 in the next cycle, with `rd_data` equal to `zone_q` as it stood in the request cycle.
- R10: A cycle with `rd_req` high and `sense_off` high yields a one-cycle `rd_reject` in the next cycle and no `rd_ack`. `rd_ack` and `rd_reject` never rise together.
- R11: Synchronous active-high `rst` clears `zone_q`, `stat_alert`, `rd_ack`, `rd_reject` and `rd_data`, and sets `hot_n` and `alert_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_mv | input | 12 | Sense voltage sample in millivolts |
| smp_vld | input | 1 | Sample valid strobe |
| sense_off | input | 1 | Sense input tied to supply; thermal function off |
| rd_req | input | 1 | Zone word read request |
| zone_q | output | 8 | Thermometer-coded zone word |
| hot_n | output | 1 | Active-low hot warning |
| alert_n | output | 1 | Active-low thermal alert |
| stat_alert | output | 1 | Non-latched alert status bit |
| rd_ack | output | 1 | Read response valid |
| rd_data | output | 8 | Zone word returned by a read |
| rd_reject | output | 1 | Read rejected because the function is off |

## Verification
Directed samples sit one millivolt below and exactly on the top and middle thresholds. These tell a >= comparison apart from a > comparison, and one bit's threshold from its neighbour's. Slow ramps up and then down across the bit 5, 6 and 7 thresholds show whether each warning releases on the lower adjacent bit or on its own set bit. Random samples from 1400 to 1900 mV are mixed with sparse strobes, disable pulses and reads. They check that the zone word holds between strobes, that reads return the word from the request cycle, and that a disable clears every output whatever state it hits.

// File: rtl/thz_pkg.sv
package thz_pkg;

    localparam int ZONES_DEF     = 8;
    localparam int SMP_W_DEF     = 12;
    localparam int BASE_MV_DEF   = 1460;
    localparam int STEP_MV_DEF   = 55;
    localparam int HOT_BIT_DEF   = 7;
    localparam int ALERT_BIT_DEF = 6;

    // response kind of the read port
    typedef enum logic [1:0] {
        RESP_NONE = 2'd0,
        RESP_ACK  = 2'd1,
        RESP_REJ  = 2'd2
    } rd_resp_e;

    // hysteresis action chosen each cycle
    typedef enum logic [1:0] {
        HY_HOLD  = 2'd0,
        HY_SET   = 2'd1,
        HY_CLEAR = 2'd2
    } hyst_act_e;

    function automatic int zone_threshold(input int base_mv, input int step_mv, input int idx);
        return base_mv + step_mv * idx;
    endfunction

    function automatic hyst_act_e hyst_decide(input logic dis, input logic set_bit, input logic rel_bit);
        if (dis)           return HY_CLEAR;
        else if (set_bit)  return HY_SET;
        else if (!rel_bit) return HY_CLEAR;
        else               return HY_HOLD;
    endfunction

endpackage

// File: rtl/thz_quantizer.sv
module thz_quantizer
    import thz_pkg::*;
#(
    parameter int ZONES   = ZONES_DEF,
    parameter int SMP_W   = SMP_W_DEF,
    parameter int BASE_MV = BASE_MV_DEF,
    parameter int STEP_MV = STEP_MV_DEF
) (
    input  logic [SMP_W-1:0] mv,
    output logic [ZONES-1:0] therm
);
    // one comparator per zone step; thresholds rise monotonically so the
    // result is a thermometer pattern by nature of the comparisons
    for (genvar i = 0; i < ZONES; i++) begin : g_cmp
        localparam int TH = zone_threshold(BASE_MV, STEP_MV, i);
        assign therm[i] = (int'(mv) >= TH);
    end
endmodule

// File: rtl/thz_zone_reg.sv
module thz_zone_reg
    import thz_pkg::*;
#(
    parameter int ZONES = ZONES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dis,
    input  logic             vld,
    input  logic [ZONES-1:0] therm,
    output logic [ZONES-1:0] zone
);
    always_ff @(posedge clk) begin
        if (rst || dis) begin
            zone <= '0;
        end else if (vld) begin
            zone <= therm;
        end
    end
endmodule

// File: rtl/thz_hyst.sv
module thz_hyst
    import thz_pkg::*;
#(
    parameter int ZONES   = ZONES_DEF,
    parameter int SET_BIT = HOT_BIT_DEF,
    parameter int REL_BIT = HOT_BIT_DEF - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dis,
    input  logic [ZONES-1:0] zone,
    output logic             warn_n
);
    hyst_act_e act;
    logic      active;

    always_comb begin
        act = hyst_decide(dis, zone[SET_BIT], zone[REL_BIT]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
        end else begin
            unique case (act)
                HY_SET:   active <= 1'b1;
                HY_CLEAR: active <= 1'b0;
                default:  active <= active;
            endcase
        end
    end

    assign warn_n = ~active;
endmodule

// File: rtl/thz_rd_port.sv
module thz_rd_port
    import thz_pkg::*;
#(
    parameter int ZONES = ZONES_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dis,
    input  logic             req,
    input  logic [ZONES-1:0] zone,
    output logic             ack,
    output logic             reject,
    output logic [ZONES-1:0] data
);
    rd_resp_e resp_d;
    rd_resp_e resp_q;

    always_comb begin
        if (!req)     resp_d = RESP_NONE;
        else if (dis) resp_d = RESP_REJ;
        else          resp_d = RESP_ACK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q <= RESP_NONE;
            data   <= '0;
        end else begin
            resp_q <= resp_d;
            if (resp_d == RESP_ACK) begin
                data <= zone;
            end
        end
    end

    assign ack    = (resp_q == RESP_ACK);
    assign reject = (resp_q == RESP_REJ);
endmodule

// File: rtl/thermal_zone_alert.sv
module thermal_zone_alert
    import thz_pkg::*;
#(
    parameter int ZONES     = ZONES_DEF,
    parameter int SMP_W     = SMP_W_DEF,
    parameter int BASE_MV   = BASE_MV_DEF,
    parameter int STEP_MV   = STEP_MV_DEF,
    parameter int HOT_BIT   = HOT_BIT_DEF,
    parameter int ALERT_BIT = ALERT_BIT_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] smp_mv,
    input  logic             smp_vld,
    input  logic             sense_off,
    input  logic             rd_req,
    output logic [ZONES-1:0] zone_q,
    output logic             hot_n,
    output logic             alert_n,
    output logic             stat_alert,
    output logic             rd_ack,
    output logic [ZONES-1:0] rd_data,
    output logic             rd_reject
);
    localparam int NWARN = 2;
    localparam int WARN_SET [NWARN] = '{HOT_BIT, ALERT_BIT};

    logic [ZONES-1:0] therm;
    logic [NWARN-1:0] warn_n;

    thz_quantizer #(
        .ZONES(ZONES), .SMP_W(SMP_W), .BASE_MV(BASE_MV), .STEP_MV(STEP_MV)
    ) u_quant (
        .mv    (smp_mv),
        .therm (therm)
    );

    thz_zone_reg #(.ZONES(ZONES)) u_zone (
        .clk   (clk),
        .rst   (rst),
        .dis   (sense_off),
        .vld   (smp_vld),
        .therm (therm),
        .zone  (zone_q)
    );

    // each warning sets on its own bit and releases on the bit below it
    for (genvar w = 0; w < NWARN; w++) begin : g_warn
        thz_hyst #(
            .ZONES(ZONES), .SET_BIT(WARN_SET[w]), .REL_BIT(WARN_SET[w] - 1)
        ) u_hyst (
            .clk    (clk),
            .rst    (rst),
            .dis    (sense_off),
            .zone   (zone_q),
            .warn_n (warn_n[w])
        );
    end

    assign hot_n      = warn_n[0];
    assign alert_n    = warn_n[1];
    assign stat_alert = ~warn_n[1];

    thz_rd_port #(.ZONES(ZONES)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .dis    (sense_off),
        .req    (rd_req),
        .zone   (zone_q),
        .ack    (rd_ack),
        .reject (rd_reject),
        .data   (rd_data)
    );
endmodule

// File: rtl/thz_chk.sv
module thz_chk #(
    parameter int ZONES     = 8,
    parameter int HOT_BIT   = 7,
    parameter int ALERT_BIT = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_vld,
    input logic             sense_off,
    input logic             rd_req,
    input logic [ZONES-1:0] zone_q,
    input logic             hot_n,
    input logic             alert_n,
    input logic             stat_alert,
    input logic             rd_ack,
    input logic             rd_reject
);
    // R2
    thermo_shape_chk: assert property (@(posedge clk) disable iff (rst)
        ((zone_q & (zone_q + 1'b1)) == '0));
    // R2
    zone_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!smp_vld && !sense_off) |=> $stable(zone_q));
    // R3
    hot_set_chk: assert property (@(posedge clk) disable iff (rst)
        (zone_q[HOT_BIT] && !sense_off) |=> !hot_n);
    // R4
    hot_rel_chk: assert property (@(posedge clk) disable iff (rst)
        (!zone_q[HOT_BIT-1]) |=> hot_n);
    // R5
    alert_set_chk: assert property (@(posedge clk) disable iff (rst)
        (zone_q[ALERT_BIT] && !sense_off) |=> !alert_n);
    // R6
    alert_rel_chk: assert property (@(posedge clk) disable iff (rst)
        (!zone_q[ALERT_BIT-1]) |=> alert_n);
    // R7
    stat_track_chk: assert property (@(posedge clk) disable iff (rst)
        stat_alert == !alert_n);
    // R8
    off_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sense_off |=> (zone_q == '0 && hot_n && alert_n));
    // R9
    rd_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !sense_off) |=> rd_ack);
    // R10
    rd_rej_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && sense_off) |=> (rd_reject && !rd_ack));
    // R10
    rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_ack, rd_reject}));
    // R11
    reset_chk: assert property (@(posedge clk)
        rst |=> (zone_q == '0 && hot_n && alert_n && !rd_ack && !rd_reject));
endmodule

bind thermal_zone_alert thz_chk #(
    .ZONES(ZONES), .HOT_BIT(HOT_BIT), .ALERT_BIT(ALERT_BIT)
) u_thz_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_vld    (smp_vld),
    .sense_off  (sense_off),
    .rd_req     (rd_req),
    .zone_q     (zone_q),
    .hot_n      (hot_n),
    .alert_n    (alert_n),
    .stat_alert (stat_alert),
    .rd_ack     (rd_ack),
    .rd_reject  (rd_reject)
);

// File: tb/test_thermal_zone_alert.sv
`timescale 1ns/1ps
module test_thermal_zone_alert;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] smp_mv = '0;
    logic        smp_vld = 1'b0;
    logic        sense_off = 1'b0;
    logic        rd_req = 1'b0;
    logic [7:0]  zone_q;
    logic        hot_n, alert_n, stat_alert, rd_ack, rd_reject;
    logic [7:0]  rd_data;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    logic [7:0] m_zone = '0, m_data = '0;
    logic m_hot = 1'b0, m_alert = 1'b0, m_ack = 1'b0, m_rej = 1'b0;

    always #10 clk = ~clk;

    thermal_zone_alert i_thermal_zone_alert (
        .clk(clk), .rst(rst), .smp_mv(smp_mv), .smp_vld(smp_vld),
        .sense_off(sense_off), .rd_req(rd_req), .zone_q(zone_q),
        .hot_n(hot_n), .alert_n(alert_n), .stat_alert(stat_alert),
        .rd_ack(rd_ack), .rd_data(rd_data), .rd_reject(rd_reject)
    );

    function automatic logic [7:0] exp_therm(input int mv);
        logic [7:0] t;
        for (int i = 0; i < 8; i++) t[i] = (mv >= 1460 + 55 * i);
        return t;
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // drive one cycle, advance the reference, compare after the edge
    task automatic step(input logic r, input logic v, input int mv, input logic off, input logic rd);
        logic [7:0] nz, nd;
        logic nh, na, nk, nj;
        string zt;
        rst = r; smp_vld = v; smp_mv = 12'(mv); sense_off = off; rd_req = rd;
        nz = (r || off) ? 8'h00 : (v ? exp_therm(mv) : m_zone);
        nh = (r || off) ? 1'b0 : (m_zone[7] ? 1'b1 : (!m_zone[6] ? 1'b0 : m_hot));
        na = (r || off) ? 1'b0 : (m_zone[6] ? 1'b1 : (!m_zone[5] ? 1'b0 : m_alert));
        nk = !r && rd && !off;
        nj = !r && rd && off;
        nd = r ? 8'h00 : (nk ? m_zone : m_data);
        @(negedge clk);
        m_zone = nz; m_hot = nh; m_alert = na; m_ack = nk; m_rej = nj; m_data = nd;
        zt = r ? "R11" : (off ? "R8" : (v ? "R1" : "R2"));
        cmp(zt, "zone_q", int'(zone_q), int'(m_zone));
        cmp(r ? "R11" : (m_hot ? "R3" : "R4"), "hot_n", int'(hot_n), int'(!m_hot));
        cmp(r ? "R11" : (m_alert ? "R5" : "R6"), "alert_n", int'(alert_n), int'(!m_alert));
        cmp("R7", "stat_alert", int'(stat_alert), int'(m_alert));
        cmp(r ? "R11" : "R9", "rd_ack", int'(rd_ack), int'(m_ack));
        cmp(r ? "R11" : "R10", "rd_reject", int'(rd_reject), int'(m_rej));
        if (m_ack) cmp("R9", "rd_data", int'(rd_data), int'(m_data));
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_7A11));
        @(negedge clk);
        // R11: reset state
        repeat (3) step(1, 1, 1900, 0, 1);
        // R1: threshold edges, >= comparison
        step(0, 1, 1459, 0, 0);
        step(0, 1, 1460, 0, 0);
        step(0, 1, 1844, 0, 0);
        step(0, 1, 1845, 0, 0);
        step(0, 0, 1400, 0, 0); // R2 hold; R3 hot asserted
        step(0, 0, 1400, 0, 1); // R9 read returns 0xFF
        // R4: fall to bit 6 only: hot must hold
        step(0, 1, 1790, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 1, 1789, 0, 0); // bit6 clears -> hot releases next
        step(0, 0, 0, 0, 0);
        // R6: alert holds at bit5, releases below it
        step(0, 1, 1735, 0, 1); // R7 read must not clear status
        step(0, 0, 0, 0, 0);
        step(0, 1, 1734, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        // ramps across the upper thresholds
        for (int mv = 1700; mv <= 1880; mv += 9) step(0, 1, mv, 0, 0);
        for (int mv = 1880; mv >= 1700; mv -= 9) step(0, 1, mv, 0, 0);
        // R8 / R10: disable while hot, samples ignored, read rejected
        step(0, 1, 1900, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 1, 1900, 1, 1);
        step(0, 1, 1900, 1, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        // random mix
        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 200) == 0, ($urandom % 3) == 0,
                 1400 + int'($urandom % 501), ($urandom % 25) == 0,
                 ($urandom % 5) == 0);
        end
        finish_run();
    end

endmodule